// File: doc/BRIEF.md
# PWM Event-Trigger Interrupt Generator

This block watches the count value of a PWM time base and produces three single-cycle outputs from it: an interrupt request and two start-of-conversion strobes for an ADC (channels A and B). Each output has its own 3-bit event selection. That selection picks one of these conditions:

- the counter reaching zero;
- the counter reaching the period value;
- either of those two;
- a match against compare value A or compare value B, qualified by the count direction.

An event fires only in the first cycle that its condition holds, so a counter that stops on a value does not fire again.

Every output latches a status flag when it fires. The three flags are gathered into one 16-bit flag word, and software clears them by writing ones through a clear-strobe vector. The interrupt flag also acts as a hold-off. While it is set, no further interrupt pulse leaves the block. One event that arrives during that time is kept pending and is issued right after the flag is cleared. The conversion strobes are not held off. They fire on every selected event whatever their flags show.

Top module: `pwm_evt_trig`

## Requirements
- R1: After a synchronous active-low reset, all three pulse outputs are low and the flag word reads 0.
- R2: Select code 0 never fires. Code 1 fires when the counter equals zero. Code 2 fires when it equals the period. Code 3 fires on either of those.
- R3: Code 4 fires when the counter equals compare A with `cnt_up`=1 (counting up). Code 5 fires on the same match with `cnt_up`=0 (counting down).
- R4: Code 6 fires when the counter equals compare B with `cnt_up`=1. Code 7 fires on the same match with `cnt_up`=0.
- R5: An event fires only in the first cycle that its condition is true. Holding the condition true does not fire it again.
- R6: A pulse is high for exactly one cycle, in the cycle right after the cycle whose inputs met the selected condition.
- R7: An interrupt pulse sets the interrupt flag (flag word bit 0). While that flag is set, no interrupt pulse is issued.
- R8: While the interrupt flag is set, one event is held pending and any further events are dropped. Clearing the flag makes it read 0 in the next cycle, and the pending interrupt pulses in the cycle after that, setting the flag again.
- R9: A conversion pulse on A sets flag word bit 2, and a conversion pulse on B sets bit 3. Conversion pulses keep firing while their flag is set.
- R10: Flag word bits 1 and 15..4 always read 0. A clear-strobe bit set to 1 clears the flag at the same bit position, and strobe bits at reserved positions have no effect.
- R11: If a flag's clear strobe and that flag's set arrive in the same cycle, the flag ends up set.
- R12: An output whose enable is 0 produces no pulse and sets no flag. For the interrupt, a disabled enable also drops any pending event.
- R13: Both conversion select fields use the same 3-bit event encoding as the interrupt select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctr_val | input | CNT_W | Time-base counter value |
| ctr_prd | input | CNT_W | Period value |
| cmp_a | input | CNT_W | Compare value A |
| cmp_b | input | CNT_W | Compare value B |
| cnt_up | input | 1 | 1 = counter incrementing, 0 = decrementing |
| int_sel | input | 3 | Interrupt event select code |
| soca_sel | input | 3 | Conversion A event select code |
| socb_sel | input | 3 | Conversion B event select code |
| int_en | input | 1 | Interrupt output enable |
| soca_en | input | 1 | Conversion A output enable |
| socb_en | input | 1 | Conversion B output enable |
| flag_clr | input | 16 | Write-one clear strobes, aligned to flag word bits |
| int_pulse | output | 1 | Interrupt pulse |
| soca_pulse | output | 1 | Conversion A start pulse |
| socb_pulse | output | 1 | Conversion B start pulse |
| evt_flags | output | 16 | Flag word: bit 0 interrupt, bit 2 conv A, bit 3 conv B |

## Verification
Directed sequences step the counter through zero, the period and both compare values, in both count directions, for every select code. These runs separate the zero, period and compare decodes from one another, and show that a match seen in the wrong count direction does not fire. Further directed sequences stack interrupt events against a set flag, clear the flag in the same cycle as a new event, and drop the enables with an event pending. These runs separate the one-slot pending behaviour from both dropping all held events and queueing more than one. A long constrained-random run over a small counter range mixes held values, select changes, random clears and enable toggles, and checks every output each cycle against a model built from the requirements.

// File: rtl/pwm_evt_pkg.sv
// Package: shared select encoding and flag word layout for the event-trigger block.
// Assumes: the select codes and flag bit positions are decoded by software.
package pwm_evt_pkg;

    localparam int SEL_W    = 3;
    localparam int FLAG_W   = 16;
    localparam int FLG_INT  = 0;
    localparam int FLG_SOCA = 2;
    localparam int FLG_SOCB = 3;
    localparam int NUM_OUT  = 3;

    typedef enum logic [SEL_W-1:0] {
        EV_NONE     = 3'd0,
        EV_ZERO     = 3'd1,
        EV_PRD      = 3'd2,
        EV_ZERO_PRD = 3'd3,
        EV_CA_UP    = 3'd4,
        EV_CA_DN    = 3'd5,
        EV_CB_UP    = 3'd6,
        EV_CB_DN    = 3'd7
    } evt_sel_e;

endpackage

// File: rtl/pwm_evt_match.sv
// Module: decodes one select code against the counter and emits a first-cycle event.
// Assumes: inputs are synchronous to clk; ev is combinational from the current inputs
// and is high only when the selected condition is true now and was false last cycle.
module pwm_evt_match
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ctr_val,
    input  logic [CNT_W-1:0] ctr_prd,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic             cnt_up,
    input  logic [SEL_W-1:0] sel,
    output logic             ev
);

    logic at_zero, at_prd, at_a, at_b;
    logic cond, cond_q;

    // Raw comparisons of the counter against its reference values.
    always_comb begin
        at_zero = (ctr_val == '0);
        at_prd  = (ctr_val == ctr_prd);
        at_a    = (ctr_val == cmp_a);
        at_b    = (ctr_val == cmp_b);
    end

    // Select the condition named by the event code.
    always_comb begin
        unique case (evt_sel_e'(sel))
            EV_NONE:     cond = 1'b0;
            EV_ZERO:     cond = at_zero;
            EV_PRD:      cond = at_prd;
            EV_ZERO_PRD: cond = at_zero | at_prd;
            EV_CA_UP:    cond = at_a & cnt_up;
            EV_CA_DN:    cond = at_a & ~cnt_up;
            EV_CB_UP:    cond = at_b & cnt_up;
            EV_CB_DN:    cond = at_b & ~cnt_up;
            default:     cond = 1'b0;
        endcase
    end

    // Remember last cycle's condition for first-cycle detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cond;
    end

    assign ev = cond & ~cond_q;

    assert_no_refire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> !ev);

    assert_reserved_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EV_NONE) |-> !ev);

endmodule

// File: rtl/pwm_soc_chan.sv
// Module: one conversion-start output with its latched status flag.
// Assumes: ev is a first-cycle event; the pulse is not held off by the flag,
// and a set beats a clear arriving in the same cycle.
module pwm_soc_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic en,
    input  logic clr,
    output logic pulse_q,
    output logic flag_q
);

    logic fire;

    assign fire = ev & en;

    // Register the pulse and update the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= fire;
            flag_q  <= fire | (flag_q & ~clr);
        end
    end

    assert_soc_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> flag_q);

    assert_soc_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !pulse_q);

    assert_soc_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && en && clr) |=> flag_q);

endmodule

// File: rtl/pwm_int_chan.sv
// Module: interrupt output with latched flag, hold-off and a single pending slot.
// Assumes: ev is a first-cycle event. While the flag is set, the first event is
// parked and later ones are dropped; disabling the output drops the parked event.
module pwm_int_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic en,
    input  logic clr,
    output logic pulse_q,
    output logic flag_q
);

    logic live_ev, issue, pend_q;

    assign live_ev = ev & en;
    assign issue   = en & ~flag_q & (live_ev | pend_q);

    // Issue, park or drop interrupt requests and maintain the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            pulse_q <= issue;
            if (!en)
                pend_q <= 1'b0;
            else if (issue)
                pend_q <= pend_q & live_ev;
            else if (flag_q && live_ev)
                pend_q <= 1'b1;
            if (issue)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
        end
    end

    assert_int_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> !pulse_q);

    assert_int_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> flag_q);

    assert_int_disabled_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pulse_q && !pend_q));

    assert_pending_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag_q) && pend_q && en) |=> pulse_q);

endmodule

// File: rtl/pwm_evt_trig.sv
// Module: top of the event-trigger block. Three event matchers feed one interrupt
// channel and two conversion-start channels; flags are packed into a 16-bit word.
// Assumes: flag_clr is a one-cycle write-one-to-clear strobe aligned to the flag word.
module pwm_evt_trig
    import pwm_evt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  ctr_val,
    input  logic [CNT_W-1:0]  ctr_prd,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cmp_b,
    input  logic              cnt_up,
    input  logic [2:0]        int_sel,
    input  logic [2:0]        soca_sel,
    input  logic [2:0]        socb_sel,
    input  logic              int_en,
    input  logic              soca_en,
    input  logic              socb_en,
    input  logic [15:0]       flag_clr,
    output logic              int_pulse,
    output logic              soca_pulse,
    output logic              socb_pulse,
    output logic [15:0]       evt_flags
);

    logic [SEL_W-1:0] sel_arr [NUM_OUT];
    logic [NUM_OUT-1:0] ev_vec, en_vec, clr_vec, pulse_vec, flag_vec;

    // Gather per-output controls into index-aligned arrays (0 int, 1 conv A, 2 conv B).
    always_comb begin
        sel_arr[0] = int_sel;
        sel_arr[1] = soca_sel;
        sel_arr[2] = socb_sel;
        en_vec     = {socb_en, soca_en, int_en};
        clr_vec    = {flag_clr[FLG_SOCB], flag_clr[FLG_SOCA], flag_clr[FLG_INT]};
    end

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_match
        pwm_evt_match #(.CNT_W(CNT_W)) u_match (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctr_val (ctr_val),
            .ctr_prd (ctr_prd),
            .cmp_a   (cmp_a),
            .cmp_b   (cmp_b),
            .cnt_up  (cnt_up),
            .sel     (sel_arr[g]),
            .ev      (ev_vec[g])
        );
    end

    pwm_int_chan u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev_vec[0]),
        .en      (en_vec[0]),
        .clr     (clr_vec[0]),
        .pulse_q (pulse_vec[0]),
        .flag_q  (flag_vec[0])
    );

    for (genvar s = 1; s < NUM_OUT; s++) begin : g_soc
        pwm_soc_chan u_soc (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev      (ev_vec[s]),
            .en      (en_vec[s]),
            .clr     (clr_vec[s]),
            .pulse_q (pulse_vec[s]),
            .flag_q  (flag_vec[s])
        );
    end

    // Drive the pulse outputs and pack the flag word; unused bits read zero.
    always_comb begin
        int_pulse           = pulse_vec[0];
        soca_pulse          = pulse_vec[1];
        socb_pulse          = pulse_vec[2];
        evt_flags           = '0;
        evt_flags[FLG_INT]  = flag_vec[0];
        evt_flags[FLG_SOCA] = flag_vec[1];
        evt_flags[FLG_SOCB] = flag_vec[2];
    end

    assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[FLG_SOCA] == 1'b0 && evt_flags[FLG_SOCA]) |=> evt_flags[FLG_SOCA]);

endmodule

// File: tb/pwm_evt_trig_test.sv
// Bench: directed corner cases followed by seeded random stimulus, every cycle
// compared against a requirement-level model kept in bench variables.
module pwm_evt_trig_test;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int MAX_CYC    = 100000;

    logic clk = 1'b0;
    logic rst_n;
    logic [CNT_W-1:0] ctr_val, ctr_prd, cmp_a, cmp_b;
    logic cnt_up;
    logic [2:0] int_sel, soca_sel, socb_sel;
    logic int_en, soca_en, socb_en;
    logic [15:0] flag_clr;
    logic int_pulse, soca_pulse, socb_pulse;
    logic [15:0] evt_flags;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    // model state
    logic [2:0] m_cq;
    logic m_ip, m_ap, m_bp, m_if, m_af, m_bf, m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_evt_trig #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .ctr_val(ctr_val), .ctr_prd(ctr_prd),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cnt_up(cnt_up),
        .int_sel(int_sel), .soca_sel(soca_sel), .socb_sel(socb_sel),
        .int_en(int_en), .soca_en(soca_en), .socb_en(socb_en),
        .flag_clr(flag_clr), .int_pulse(int_pulse), .soca_pulse(soca_pulse),
        .socb_pulse(socb_pulse), .evt_flags(evt_flags)
    );

    function automatic logic cond_of(input logic [2:0] sel);
        case (sel)
            3'd1: cond_of = (ctr_val == 0);
            3'd2: cond_of = (ctr_val == ctr_prd);
            3'd3: cond_of = (ctr_val == 0) || (ctr_val == ctr_prd);
            3'd4: cond_of = (ctr_val == cmp_a) && cnt_up;
            3'd5: cond_of = (ctr_val == cmp_a) && !cnt_up;
            3'd6: cond_of = (ctr_val == cmp_b) && cnt_up;
            3'd7: cond_of = (ctr_val == cmp_b) && !cnt_up;
            default: cond_of = 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] m_word();
        m_word = {12'd0, m_bf, m_af, 1'b0, m_if};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance the model by one edge using the inputs now applied.
    task automatic model_step();
        logic [2:0] c, e;
        logic ie, iss;
        if (!rst_n) begin
            m_cq = '0; m_ip = 0; m_ap = 0; m_bp = 0;
            m_if = 0; m_af = 0; m_bf = 0; m_pend = 0;
            return;
        end
        c = {cond_of(socb_sel), cond_of(soca_sel), cond_of(int_sel)};
        e = c & ~m_cq;
        m_cq = c;
        m_ap = e[1] & soca_en;
        m_af = m_ap | (m_af & ~flag_clr[2]);
        m_bp = e[2] & socb_en;
        m_bf = m_bp | (m_bf & ~flag_clr[3]);
        ie  = e[0] & int_en;
        iss = int_en & ~m_if & (ie | m_pend);
        if (!int_en)      m_pend = 0;
        else if (iss)     m_pend = m_pend & ie;
        else if (m_if && ie) m_pend = 1;
        m_ip = iss;
        if (iss)               m_if = 1;
        else if (flag_clr[0])  m_if = 0;
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(int_pulse == m_ip, "R7 int pulse vs model", {15'd0, int_pulse}, {15'd0, m_ip});
        chk(soca_pulse == m_ap, "R6 soca pulse vs model", {15'd0, soca_pulse}, {15'd0, m_ap});
        chk(socb_pulse == m_bp, "R6 socb pulse vs model", {15'd0, socb_pulse}, {15'd0, m_bp});
        chk(evt_flags == m_word(), "R10 flag word vs model", evt_flags, m_word());
    endtask

    task automatic chk1(input logic act, input logic exp, input string tag);
        chk(act === exp, tag, {15'd0, act}, {15'd0, exp});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > MAX_CYC) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, MAX_CYC);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int unsigned r;
        seed = 32'd1234;
        r = $urandom(seed);
        rst_n = 0; ctr_val = 5; ctr_prd = 10; cmp_a = 3; cmp_b = 6; cnt_up = 1;
        int_sel = 0; soca_sel = 0; socb_sel = 0;
        int_en = 0; soca_en = 0; socb_en = 0; flag_clr = 0;
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        tick();
        chk(evt_flags == 16'h0000, "R1 flags after reset", evt_flags, 16'h0000);
        chk1(int_pulse | soca_pulse | socb_pulse, 1'b0, "R1 pulses low after reset");

        // interrupt on zero
        int_sel = 1; int_en = 1; ctr_val = 0; tick();
        chk1(int_pulse, 1'b1, "R2 R6 code1 zero fires int");
        chk1(evt_flags[0], 1'b1, "R7 int flag set");
        tick();
        chk1(int_pulse, 1'b0, "R5 R6 held zero no refire");

        // conversion A decodes
        ctr_val = 5; soca_en = 1; soca_sel = 2; tick();
        ctr_val = 10; tick();
        chk1(soca_pulse, 1'b1, "R2 code2 period fires");
        chk1(evt_flags[2], 1'b1, "R9 soca flag set");
        ctr_val = 5; tick();
        soca_sel = 3; ctr_val = 0; tick();
        chk1(soca_pulse, 1'b1, "R2 code3 zero fires");
        ctr_val = 5; tick();
        ctr_val = 10; tick();
        chk1(soca_pulse, 1'b1, "R2 R9 code3 period fires with flag set");
        ctr_val = 5; soca_sel = 0; tick();
        ctr_val = 0; tick();
        chk1(soca_pulse, 1'b0, "R2 code0 never fires");
        ctr_val = 4; soca_sel = 4; cnt_up = 0; tick();
        ctr_val = 3; tick();
        chk1(soca_pulse, 1'b0, "R3 code4 ignores down match");
        ctr_val = 4; tick();
        soca_sel = 5; ctr_val = 3; tick();
        chk1(soca_pulse, 1'b1, "R3 code5 fires on down match");
        ctr_val = 2; cnt_up = 1; soca_sel = 4; tick();
        ctr_val = 3; tick();
        chk1(soca_pulse, 1'b1, "R3 code4 fires on up match");

        // conversion B decodes
        ctr_val = 2; socb_en = 1; socb_sel = 6; tick();
        ctr_val = 6; tick();
        chk1(socb_pulse, 1'b1, "R4 R13 code6 fires on up match");
        ctr_val = 7; cnt_up = 0; tick();
        ctr_val = 6; tick();
        chk1(socb_pulse, 1'b0, "R4 code6 ignores down match");
        ctr_val = 7; socb_sel = 7; tick();
        ctr_val = 6; tick();
        chk1(socb_pulse, 1'b1, "R4 R13 code7 fires on down match");
        chk(evt_flags == 16'h000D, "R10 flag word layout", evt_flags, 16'h000D);

        // hold-off with one pending slot (one event already parked)
        ctr_val = 5; cnt_up = 1; tick();
        ctr_val = 0; tick();
        chk1(int_pulse, 1'b0, "R7 held off while flag set");
        flag_clr = 16'hFFF2; tick();
        chk(evt_flags == 16'h000D, "R10 reserved clear bits no effect", evt_flags, 16'h000D);
        flag_clr = 16'h0001; tick();
        chk1(evt_flags[0], 1'b0, "R8 flag reads 0 after clear");
        chk1(int_pulse, 1'b0, "R8 no pulse in clear cycle");
        flag_clr = 0; tick();
        chk1(int_pulse, 1'b1, "R8 pending issued after clear");
        chk1(evt_flags[0], 1'b1, "R8 flag set again");
        flag_clr = 16'h0001; tick();
        flag_clr = 0; tick();
        chk1(int_pulse, 1'b0, "R8 only one event was pending");

        // set wins over clear
        flag_clr = 16'h0001; tick();
        flag_clr = 0; ctr_val = 5; tick();
        ctr_val = 0; flag_clr = 16'h0001; tick();
        chk1(int_pulse, 1'b1, "R11 int fires with clear");
        chk1(evt_flags[0], 1'b1, "R11 int set beats clear");
        flag_clr = 0; soca_sel = 1; ctr_val = 5; tick();
        ctr_val = 0; flag_clr = 16'h0004; tick();
        chk1(evt_flags[2], 1'b1, "R11 soca set beats clear");

        // disable drops pending and blocks outputs
        flag_clr = 0; int_en = 0; tick();
        flag_clr = 16'h0001; tick();
        flag_clr = 0; tick();
        chk1(int_pulse, 1'b0, "R12 disabled int no pulse");
        chk1(evt_flags[0], 1'b0, "R12 disabled int flag stays clear");
        int_en = 1; tick();
        chk1(int_pulse, 1'b0, "R12 pending dropped by disable");
        soca_en = 0; flag_clr = 16'h0004; tick();
        flag_clr = 0; ctr_val = 5; tick();
        ctr_val = 0; tick();
        chk1(soca_pulse, 1'b0, "R12 disabled soca no pulse");
        chk1(evt_flags[2], 1'b0, "R12 disabled soca no flag");

        // constrained random run
        for (int i = 0; i < 4000; i++) begin
            ctr_val  = CNT_W'($urandom_range(0, 11));
            if ($urandom_range(0, 9) == 0) ctr_prd = CNT_W'($urandom_range(0, 11));
            if ($urandom_range(0, 9) == 0) cmp_a   = CNT_W'($urandom_range(0, 11));
            if ($urandom_range(0, 9) == 0) cmp_b   = CNT_W'($urandom_range(0, 11));
            cnt_up   = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 15) == 0) int_sel  = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) soca_sel = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) socb_sel = 3'($urandom_range(0, 7));
            int_en   = ($urandom_range(0, 19) != 0);
            soca_en  = ($urandom_range(0, 9) != 0);
            socb_en  = ($urandom_range(0, 9) != 0);
            flag_clr = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
            tick();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule